// File: doc/BRIEF.md
# Keyboard Latch and Strobe Register

This block holds the most recent key code for an 8-bit CPU bus. The code arrives as a 7-bit value with a one-cycle valid pulse. Each key event stores the code and raises a "new key" flag, the strobe, in bit 7 of the stored byte. The block also keeps an any-key-down flag. That flag follows a separate key-held level, and a key event sets it as well.

The CPU reaches the block through a 32-byte window at a base address (default C000). A read of any of the lower sixteen addresses returns the stored byte with its strobe. A read of the first upper address (C010) returns the key-held status in bit 7 and also clears the strobe. A write of any data to any upper address (C010–C01F) clears the strobe too.

Read data is combinational from the current state. Every change of state takes effect at the next clock edge. Other functions that share this window are outside this block. Scanning and debouncing of the keys are outside it as well.

Top module: `kbd_latch`

## Requirements
- R1: After reset the stored byte is 0x00 and the any-key-down flag is clear, so a read of C000 returns 0x00 and a read of C010 returns 0x00.
- R2: A key event (key_valid high) stores {1, key_code} in the byte from the next clock edge. Bit 7 is the strobe and bits 6:0 are the code.
- R3: A read (bus_rd) of any address C000–C00F returns the full stored byte, strobe included, in the same cycle, with rd_hit high.
- R4: A read of C010 returns 0x80 when the any-key-down flag is set and 0x00 otherwise, with rd_hit high. From the next edge, bit 7 of the stored byte is 0 and bits 6:0 are unchanged.
- R5: A write (bus_wr) to any address C010–C01F clears bit 7 of the stored byte from the next edge and leaves bits 6:0 unchanged.
- R6: From each clock edge the any-key-down flag equals the key_held value sampled at that edge, or is 1 when a key event was sampled. Clearing accesses do not affect it.
- R7: When a key event arrives in the same cycle as a strobe-clearing access, the new key is stored with bit 7 set.
- R8: Accesses that are not listed above have no effect on the stored byte: writes to C000–C00F and accesses outside the window. Reads of C011–C01F and of addresses outside the window return 0x00 with rd_hit low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| key_valid | input | 1 | One-cycle key event pulse |
| key_code | input | 7 | Key code carried by the event |
| key_held | input | 1 | Level: some key is held down |
| bus_addr | input | 16 | CPU address |
| bus_rd | input | 1 | CPU read strobe for this cycle |
| bus_wr | input | 1 | CPU write strobe for this cycle |
| rd_data | output | 8 | Read data for the window addresses |
| rd_hit | output | 1 | High when this block drives the read |

## Verification
Read data and rd_hit are due in the same cycle as the access. The bench therefore drives each access just after a falling edge and samples the outputs a short delay later, before the next rising edge. Any change to the stored byte or the any-key-down flag is due at the next rising edge. The bench's model updates its state at that edge, and these changes are observed by later reads in the following cycles. Collisions between a key event and a clearing access, and key_held changes that coincide with an event, are placed so that the next read shows the result of exactly one edge.

// File: rtl/kbd_pkg.sv
package kbd_pkg;
    localparam int KBD_CODE_W = 7;

    typedef struct packed {
        logic rd_data;   // read of the latch half of the window
        logic rd_stat;   // read of the status address
        logic clr;       // access that clears the strobe
    } kbd_access_t;

    typedef struct packed {
        logic                  strobe;
        logic [KBD_CODE_W-1:0] code;
        logic                  akd;
    } kbd_state_t;
endpackage

// File: rtl/kbd_decode.sv
module kbd_decode
    import kbd_pkg::*;
#(
    parameter int ADDR_W = 16,
    parameter logic [ADDR_W-1:0] BASE = 16'hC000
) (
    input  logic [ADDR_W-1:0] addr,
    input  logic              rd,
    input  logic              wr,
    output kbd_access_t       acc
);
    localparam int WIN_LSB = 5;
    localparam int HALF_BIT = WIN_LSB - 1;

    logic in_win;
    logic upper;
    logic first;

    always_comb begin
        in_win = (addr[ADDR_W-1:WIN_LSB] == BASE[ADDR_W-1:WIN_LSB]);
        upper  = addr[HALF_BIT];
        first  = (addr[HALF_BIT-1:0] == '0);
        acc.rd_data = rd & in_win & ~upper;
        acc.rd_stat = rd & in_win & upper & first;
        acc.clr     = acc.rd_stat | (wr & in_win & upper);
    end
endmodule

// File: rtl/kbd_state.sv
module kbd_state
    import kbd_pkg::*;
(
    input  logic                  clk,
    input  logic                  rst_n,
    input  logic                  key_valid,
    input  logic [KBD_CODE_W-1:0] key_code,
    input  logic                  key_held,
    input  logic                  clr,
    output kbd_state_t            st_q
);
    kbd_state_t st_d;

    always_comb begin
        st_d     = st_q;
        st_d.akd = key_held;
        if (clr) begin
            st_d.strobe = 1'b0;
        end
        if (key_valid) begin
            st_d.strobe = 1'b1;
            st_d.code   = key_code;
            st_d.akd    = 1'b1;
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            st_q <= '0;
        end else begin
            st_q <= st_d;
        end
    end
endmodule

// File: rtl/kbd_rdmux.sv
module kbd_rdmux
    import kbd_pkg::*;
(
    input  kbd_access_t       acc,
    input  kbd_state_t        st,
    output logic [KBD_CODE_W:0] rd_data,
    output logic              rd_hit
);
    always_comb begin
        rd_data = '0;
        if (acc.rd_data) begin
            rd_data = {st.strobe, st.code};
        end else if (acc.rd_stat) begin
            rd_data = {st.akd, {KBD_CODE_W{1'b0}}};
        end
        rd_hit = acc.rd_data | acc.rd_stat;
    end
endmodule

// File: rtl/kbd_latch.sv
module kbd_latch
    import kbd_pkg::*;
#(
    parameter int ADDR_W = 16,
    parameter logic [ADDR_W-1:0] BASE = 16'hC000
) (
    input  logic                  clk,
    input  logic                  rst_n,
    input  logic                  key_valid,
    input  logic [KBD_CODE_W-1:0] key_code,
    input  logic                  key_held,
    input  logic [ADDR_W-1:0]     bus_addr,
    input  logic                  bus_rd,
    input  logic                  bus_wr,
    output logic [KBD_CODE_W:0]   rd_data,
    output logic                  rd_hit
);
    kbd_access_t acc;
    kbd_state_t  st_q;
    logic [KBD_CODE_W:0] latch_q;
    logic akd_q;

    kbd_decode #(.ADDR_W(ADDR_W), .BASE(BASE)) u_dec (
        .addr (bus_addr),
        .rd   (bus_rd),
        .wr   (bus_wr),
        .acc  (acc)
    );

    kbd_state u_st (
        .clk       (clk),
        .rst_n     (rst_n),
        .key_valid (key_valid),
        .key_code  (key_code),
        .key_held  (key_held),
        .clr       (acc.clr),
        .st_q      (st_q)
    );

    kbd_rdmux u_mux (
        .acc     (acc),
        .st      (st_q),
        .rd_data (rd_data),
        .rd_hit  (rd_hit)
    );

    assign latch_q = {st_q.strobe, st_q.code};
    assign akd_q   = st_q.akd;
endmodule

// File: rtl/kbd_latch_chk.sv
module kbd_latch_chk
    import kbd_pkg::*;
#(
    parameter int ADDR_W = 16,
    parameter logic [ADDR_W-1:0] BASE = 16'hC000
) (
    input logic                  clk,
    input logic                  rst_n,
    input logic                  key_valid,
    input logic [KBD_CODE_W-1:0] key_code,
    input logic                  key_held,
    input logic [ADDR_W-1:0]     bus_addr,
    input logic                  bus_rd,
    input logic                  bus_wr,
    input logic [KBD_CODE_W:0]   rd_data,
    input logic                  rd_hit,
    input logic [KBD_CODE_W:0]   latch_q,
    input logic                  akd_q
);
    logic win, lo_half, stat_addr, clr_acc;
    always_comb begin
        win       = (bus_addr[ADDR_W-1:5] == BASE[ADDR_W-1:5]);
        lo_half   = win && !bus_addr[4];
        stat_addr = win && (bus_addr[4:0] == 5'h10);
        clr_acc   = (bus_rd && stat_addr) || (bus_wr && win && bus_addr[4]);
    end

    AST_KEY_LOAD: assert property (@(posedge clk) disable iff (!rst_n)
        key_valid |=> latch_q == {1'b1, $past(key_code)}); // R2
    AST_LO_READ: assert property (@(posedge clk) disable iff (!rst_n)
        (bus_rd && lo_half) |-> (rd_hit && rd_data == latch_q)); // R3
    AST_STAT_CLEAR: assert property (@(posedge clk) disable iff (!rst_n)
        (!key_valid && bus_rd && stat_addr) |=>
            (!latch_q[KBD_CODE_W] && latch_q[KBD_CODE_W-1:0] == $past(latch_q[KBD_CODE_W-1:0]))); // R4
    AST_WR_CLEAR: assert property (@(posedge clk) disable iff (!rst_n)
        (!key_valid && bus_wr && win && bus_addr[4]) |=> !latch_q[KBD_CODE_W]); // R5
    AST_AKD_FOLLOW: assert property (@(posedge clk) disable iff (!rst_n)
        !key_valid |=> akd_q == $past(key_held)); // R6
    AST_QUIET: assert property (@(posedge clk) disable iff (!rst_n)
        (!key_valid && !clr_acc) |=> $stable(latch_q)); // R8
    AST_HIT_ONLY_READ: assert property (@(posedge clk) disable iff (!rst_n)
        rd_hit |-> (bus_rd && (lo_half || stat_addr))); // R8
endmodule

bind kbd_latch kbd_latch_chk #(.ADDR_W(ADDR_W), .BASE(BASE)) u_chk (
    .clk       (clk),
    .rst_n     (rst_n),
    .key_valid (key_valid),
    .key_code  (key_code),
    .key_held  (key_held),
    .bus_addr  (bus_addr),
    .bus_rd    (bus_rd),
    .bus_wr    (bus_wr),
    .rd_data   (rd_data),
    .rd_hit    (rd_hit),
    .latch_q   (latch_q),
    .akd_q     (akd_q)
);

// File: tb/tb_kbd_latch.sv
module tb_kbd_latch;
    localparam int CLK_PERIOD = 10;
    localparam int N_RANDOM = 4000;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        key_valid = 1'b0;
    logic [6:0]  key_code = '0;
    logic        key_held = 1'b0;
    logic [15:0] bus_addr = '0;
    logic        bus_rd = 1'b0;
    logic        bus_wr = 1'b0;
    logic [7:0]  rd_data;
    logic        rd_hit;

    int checks = 0;
    int errors = 0;
    logic [7:0] m_latch = 8'h00;
    logic       m_akd = 1'b0;

    always #(CLK_PERIOD/2) clk = ~clk;

    kbd_latch dut (
        .clk(clk), .rst_n(rst_n), .key_valid(key_valid), .key_code(key_code),
        .key_held(key_held), .bus_addr(bus_addr), .bus_rd(bus_rd), .bus_wr(bus_wr),
        .rd_data(rd_data), .rd_hit(rd_hit)
    );

    function automatic logic [8:0] exp_read(logic [15:0] a, logic [7:0] lat, logic akd);
        if (a[15:4] == 12'hC00) return {1'b1, lat};
        if (a == 16'hC010)      return {1'b1, akd, 7'b0};
        return 9'h000;
    endfunction

    function automatic logic is_clear(logic [15:0] a, logic rd, logic wr);
        return (rd && a == 16'hC010) || (wr && a[15:4] == 12'hC01);
    endfunction

    task automatic check(string tag, logic [8:0] act, logic [8:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s: actual hit/data=%h expected=%h", tag, act, exp);
        end
    endtask

    task automatic cyc(string tag, logic kv, logic [6:0] code, logic held,
                       logic [15:0] a, logic rd, logic wr);
        @(negedge clk);
        key_valid = kv; key_code = code; key_held = held;
        bus_addr = a; bus_rd = rd; bus_wr = wr;
        #1;
        if (rd) check(tag, {rd_hit, rd_data}, exp_read(a, m_latch, m_akd));
        @(posedge clk);
        if (is_clear(a, rd, wr)) m_latch[7] = 1'b0;
        m_akd = held;
        if (kv) begin
            m_latch = {1'b1, code};
            m_akd = 1'b1;
        end
    endtask

    task automatic rd(string tag, logic [15:0] a, logic held);
        cyc(tag, 1'b0, 7'h0, held, a, 1'b1, 1'b0);
    endtask

    initial begin
        #(CLK_PERIOD * 200000);
        errors++;
        $display("FAIL watchdog: actual=hung expected=finished");
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

    initial begin
        void'($urandom(32'h5EED1234));
        repeat (3) @(posedge clk);
        @(negedge clk);
        rst_n = 1'b1;
        // R1 reset state
        rd("R1", 16'hC000, 1'b0);
        rd("R1", 16'hC010, 1'b0);
        // R2 key load, R3 reads across lower half
        cyc("R2", 1'b1, 7'h41, 1'b1, 16'h0000, 1'b0, 1'b0);
        rd("R2", 16'hC000, 1'b1);
        rd("R3", 16'hC005, 1'b1);
        rd("R3", 16'hC00F, 1'b1);
        // R4 status read returns held and clears strobe
        rd("R4", 16'hC010, 1'b1);
        rd("R4", 16'hC000, 1'b1);
        // R6 key_held drop visible; clear does not touch flag
        rd("R6", 16'hC010, 1'b0);
        rd("R6", 16'hC010, 1'b0);
        // R5 write clears strobe
        cyc("R5", 1'b1, 7'h22, 1'b0, 16'h0000, 1'b0, 1'b0);
        cyc("R5", 1'b0, 7'h0, 1'b0, 16'hC01F, 1'b0, 1'b1);
        rd("R5", 16'hC000, 1'b0);
        // R8 no-effect accesses
        cyc("R8", 1'b1, 7'h13, 1'b0, 16'h0000, 1'b0, 1'b0);
        cyc("R8", 1'b0, 7'h0, 1'b0, 16'hC005, 1'b0, 1'b1);
        cyc("R8", 1'b0, 7'h0, 1'b0, 16'hC030, 1'b0, 1'b1);
        rd("R8", 16'hC011, 1'b0);
        rd("R8", 16'hC020, 1'b0);
        rd("R8", 16'hC000, 1'b0);
        // R7 key event collides with clearing read and write
        cyc("R7", 1'b1, 7'h55, 1'b0, 16'hC010, 1'b1, 1'b0);
        rd("R7", 16'hC000, 1'b0);
        cyc("R7", 1'b1, 7'h2A, 1'b0, 16'hC018, 1'b0, 1'b1);
        rd("R7", 16'hC000, 1'b0);
        // R6 key event sets flag even with key_held low
        cyc("R6", 1'b1, 7'h01, 1'b0, 16'h0000, 1'b0, 1'b0);
        rd("R6", 16'hC010, 1'b0);
        // random mix
        for (int i = 0; i < N_RANDOM; i++) begin
            logic [15:0] a;
            logic kv, held, r, w;
            int sel;
            sel = $urandom_range(0, 5);
            case (sel)
                0: a = 16'hC000 | 16'($urandom_range(0, 15));
                1: a = 16'hC010;
                2: a = 16'hC010 | 16'($urandom_range(0, 15));
                3: a = 16'hC020 | 16'($urandom_range(0, 31));
                4: a = 16'($urandom);
                default: a = 16'hC000;
            endcase
            kv = ($urandom_range(0, 3) == 0);
            held = $urandom_range(0, 1) == 1;
            r = $urandom_range(0, 2) != 0;
            w = !r && ($urandom_range(0, 1) == 1);
            if (a[15:4] == 12'hC00) cyc("R3", kv, 7'($urandom), held, a, r, w);
            else if (a == 16'hC010) cyc("R4", kv, 7'($urandom), held, a, r, w);
            else cyc("R8", kv, 7'($urandom), held, a, r, w);
        end
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end
endmodule